// File: doc/BRIEF.md
# Configuration Word Stream Packet Parser

This block sits on the path that feeds a device's configuration logic. It takes one 32-bit configuration word per accepted handshake and, in a single pass, hunts for the alignment pattern, works out the byte order of the stream, splits packet headers into their fields and turns every payload word of a write into a strobe. That strobe carries the target register address and the data. Writes to the frame-address register are also split into their five fields. Writes to the command register are checked against the set of legal codes and flagged.

The control path is a single state machine with six named states. `ST_HUNT` discards everything until the alignment word `0xAA995566` arrives (transition *hunt→header*). It also watches for the reversed width-detect word, which switches on byte reversal. `ST_HEADER` decodes headers and skips pad words. It moves to `ST_PAYLOAD` for a counted packet (*header→payload*), to `ST_FRAMEADR` for a frame-address write (*header→frameadr*) and to `ST_COMMAND` for a command write (*header→command*). `ST_PAYLOAD` counts words down and returns on the last one (*payload→header*). `ST_FRAMEADR` returns to the header state (*frameadr→header*). `ST_COMMAND` returns either to the header state (*command→header*) or to the hunt state after a desynchronise code (*command→hunt*). Any illegal input takes the machine to `ST_HALT` (*any→halt*), where it stays until reset. While halted it refuses input and holds its error output.

Top module: `cfg_pkt_parser`

## Requirements
- R1: After reset, `in_ready` is 1, `err` is 0, and `wr_strobe`, `far_strobe` and `cmd_strobe` are 0.
- R2: Before the alignment word `0xAA995566` has been accepted, every word produces no strobe, including words that would decode as valid write headers. The pad word `0xFFFFFFFF` and the width-detect words `0x000000BB` and `0x11220044` are among them. Accepting the alignment word makes the next word a header.
- R3: In the header state, the pad word `0xFFFFFFFF` is discarded without effect, and the following word is still decoded as a header.
- R4: If `0xBB000000` is accepted in the hunt state, the bytes of every later word are reversed (byte 0 swapped with byte 3, byte 1 with byte 2) before any decoding, and reversed words appear on `wr_data`. A second reversal request is an error. In reversed mode this is a raw `0x000000BB` arriving in the hunt state.
- R5: A header with bits [31:29]=1 is Type 1. Its opcode is in [28:27] (0 no-op, 1 read, 2 write), its register address in [17:13] and its word count in [9:0]. The next count words are payload. For a write, each payload word raises `wr_strobe` for one cycle with `wr_addr` set to the address and `wr_data` set to the word. For a no-op or a read, the payload is consumed with no strobe.
- R6: A header whose word count is 0 consumes no payload, and the next word is decoded as a header.
- R7: A header with bits [31:29]=2 is Type 2. Its word count is in [25:0], and its payload goes to the address of the most recent Type 1 header, or to address 0 if there has been none since reset. This holds even when that address is the frame-address or command register.
- R8: A Type 1 write to address 1 (frame address) must have a count of exactly 1, or `err` is set. Its payload word raises `wr_strobe` and `far_strobe` together, with `far_blk`=[25:23], `far_top`=[22], `far_row`=[21:17], `far_col`=[16:7] and `far_minor`=[6:0]. A block type other than 0, 1, 2 or 7 sets `err` and produces no strobe.
- R9: A Type 1 write to address 4 (command) must have a count of exactly 1, or `err` is set. A payload word whose value is one of 0, 1, 2, 3, 4, 5, 7, 8, 9, 10, 11 or 13 raises `wr_strobe` and `cmd_strobe` together, with `cmd_code` set to the value. Any other value sets `err` and produces no strobe.
- R10: Accepting command code 13 (desynchronise) returns the parser to the hunt state, and later headers are ignored until the alignment word is seen again. The byte-order setting is kept.
- R11: A header with a packet type other than 1 or 2, or with opcode 3, sets `err`. Once set, `err` stays 1 and `in_ready` stays 0 until reset, and no further strobes occur.
- R12: Every output reacts to an accepted word exactly one clock cycle after the edge that accepts it. A cycle with no accepted word raises no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A word is offered on `in_data` |
| in_data | input | 32 | Raw configuration word |
| in_ready | output | 1 | Parser accepts a word this cycle |
| wr_strobe | output | 1 | One-cycle strobe per written payload word |
| wr_addr | output | 5 | Target register address of the write |
| wr_data | output | 32 | Payload word after byte-order correction |
| far_strobe | output | 1 | The write carries a decoded frame address |
| far_blk | output | 3 | Frame address block type |
| far_top | output | 1 | Frame address top/bottom half |
| far_row | output | 5 | Frame address row |
| far_col | output | 10 | Frame address column |
| far_minor | output | 7 | Frame address minor index |
| cmd_strobe | output | 1 | The write carries a legal command code |
| cmd_code | output | 5 | Command code |
| err | output | 1 | Sticky error flag |

## Verification
The generic write strobe and a decoded side strobe, frame-address or command, fire in the same cycle for the same word. The bench drives frame-address and command writes both in directed runs and mixed in random packet streams. On every such cycle it checks that both strobes, the shared address and data, and the decoded fields agree with its own packet model. A second coincidence is the desynchronise command: in one accepted word it both strobes and drops the parser back to hunting. The bench follows it at once with a valid write header, which must produce no strobe, and then with a re-alignment word.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    localparam int WORD_W    = 32;
    localparam int REG_W     = 5;
    localparam int T1_CNT_W  = 10;
    localparam int HDR_CNT_W = 26;

    localparam logic [WORD_W-1:0] W_PAD       = 32'hFFFF_FFFF;
    localparam logic [WORD_W-1:0] W_WIDTH_A   = 32'h0000_00BB;
    localparam logic [WORD_W-1:0] W_WIDTH_REV = 32'hBB00_0000;
    localparam logic [WORD_W-1:0] W_WIDTH_B   = 32'h1122_0044;
    localparam logic [WORD_W-1:0] W_ALIGN     = 32'hAA99_5566;

    localparam logic [REG_W-1:0] REG_FRAME_ADR = 5'd1;
    localparam logic [REG_W-1:0] REG_COMMAND   = 5'd4;
    localparam logic [4:0]       CMD_DESYNC    = 5'd13;

    typedef enum logic [2:0] {
        ST_HUNT, ST_HEADER, ST_PAYLOAD, ST_FRAMEADR, ST_COMMAND, ST_HALT
    } cfgp_state_e;

    typedef enum logic [1:0] {OP_NOP, OP_READ, OP_WRITE, OP_RSVD} cfgp_op_e;

    typedef struct packed {
        logic [2:0] blk;
        logic       top;
        logic [4:0] row;
        logic [9:0] col;
        logic [6:0] minor;
    } cfgp_frame_t;

    typedef struct packed {
        logic                 is_t1;
        logic                 is_t2;
        cfgp_op_e             op;
        logic [REG_W-1:0]     addr;
        logic [T1_CNT_W-1:0]  cnt1;
        logic [HDR_CNT_W-1:0] cnt2;
    } cfgp_hdr_t;

    function automatic logic [WORD_W-1:0] byte_rev(input logic [WORD_W-1:0] w);
        for (int b = 0; b < WORD_W / 8; b++)
            byte_rev[8*b +: 8] = w[WORD_W-8-8*b +: 8];
    endfunction

    function automatic cfgp_hdr_t split_hdr(input logic [WORD_W-1:0] w);
        cfgp_hdr_t h;
        h.is_t1 = (w[31:29] == 3'd1);
        h.is_t2 = (w[31:29] == 3'd2);
        h.op    = cfgp_op_e'(w[28:27]);
        h.addr  = w[17:13];
        h.cnt1  = w[9:0];
        h.cnt2  = w[25:0];
        return h;
    endfunction

endpackage

// File: rtl/cfgp_order.sv
module cfgp_order
    import cfgp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_rev,
    input  logic [WORD_W-1:0] raw_word,
    output logic              rev_active,
    output logic [WORD_W-1:0] norm_word
);
    logic rev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rev_q <= 1'b0;
        else if (set_rev) rev_q <= 1'b1;
    end

    assign rev_active = rev_q;
    assign norm_word  = rev_q ? byte_rev(raw_word) : raw_word;

    // R4: once byte reversal is on it stays on until reset
    assert_rev_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rev_active |=> rev_active);

endmodule

// File: rtl/cfgp_val_chk.sv
module cfgp_val_chk
    import cfgp_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output cfgp_frame_t       frame,
    output logic              frame_ok,
    output logic              cmd_ok
);
    assign frame = cfgp_frame_t'(word[25:0]);

    always_comb begin
        unique case (frame.blk)
            3'd0, 3'd1, 3'd2, 3'd7: frame_ok = 1'b1;
            default:                frame_ok = 1'b0;
        endcase
    end

    always_comb begin
        cmd_ok = 1'b0;
        if (word[WORD_W-1:5] == '0) begin
            unique case (word[4:0])
                5'd0, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 5'd7,
                5'd8, 5'd9, 5'd10, 5'd11, 5'd13: cmd_ok = 1'b1;
                default:                         cmd_ok = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/cfg_pkt_parser.sv
module cfg_pkt_parser
    import cfgp_pkg::*;
#(
    parameter int CNT_W = HDR_CNT_W
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_ready,
    output logic              wr_strobe,
    output logic [REG_W-1:0]  wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic              far_strobe,
    output logic [2:0]        far_blk,
    output logic              far_top,
    output logic [4:0]        far_row,
    output logic [9:0]        far_col,
    output logic [6:0]        far_minor,
    output logic              cmd_strobe,
    output logic [4:0]        cmd_code,
    output logic              err
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    cfgp_state_e          state_q, state_d;
    logic [REG_W-1:0]     last_q, last_d;
    logic [CNT_W-1:0]     remain_q, remain_d;
    logic                 pwr_q, pwr_d;
    logic                 accept, set_rev, rev_active, fault;
    logic                 o_wr, o_far, o_cmd;
    logic [WORD_W-1:0]    norm;
    logic [HDR_CNT_W-1:0] pkt_cnt;
    cfgp_hdr_t            hdr;
    cfgp_frame_t          frame;
    logic                 frame_ok, cmd_ok;

    assign in_ready = (state_q != ST_HALT);
    assign accept   = in_valid && in_ready;
    assign hdr      = split_hdr(norm);

    cfgp_order u_order (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_rev    (set_rev),
        .raw_word   (in_data),
        .rev_active (rev_active),
        .norm_word  (norm)
    );

    cfgp_val_chk u_chk (
        .word     (norm),
        .frame    (frame),
        .frame_ok (frame_ok),
        .cmd_ok   (cmd_ok)
    );

    // next-state and strobe decisions
    always_comb begin
        state_d  = state_q;
        last_d   = last_q;
        remain_d = remain_q;
        pwr_d    = pwr_q;
        set_rev  = 1'b0;
        fault    = 1'b0;
        o_wr     = 1'b0;
        o_far    = 1'b0;
        o_cmd    = 1'b0;
        pkt_cnt  = hdr.is_t1 ? HDR_CNT_W'(hdr.cnt1) : hdr.cnt2;
        if (accept) begin
            unique case (state_q)
                ST_HUNT: begin
                    if (norm == W_WIDTH_REV) begin
                        if (rev_active) fault   = 1'b1;
                        else            set_rev = 1'b1;
                    end else if (norm == W_ALIGN) begin
                        state_d = ST_HEADER;
                    end
                end
                ST_HEADER: begin
                    if (norm != W_PAD) begin
                        if (hdr.op == OP_RSVD || !(hdr.is_t1 || hdr.is_t2)) begin
                            fault = 1'b1;
                        end else begin
                            if (hdr.is_t1) last_d = hdr.addr;
                            if (hdr.is_t1 && hdr.op == OP_WRITE && hdr.addr == REG_FRAME_ADR) begin
                                if (hdr.cnt1 != T1_CNT_W'(1)) fault = 1'b1;
                                else state_d = ST_FRAMEADR;
                            end else if (hdr.is_t1 && hdr.op == OP_WRITE && hdr.addr == REG_COMMAND) begin
                                if (hdr.cnt1 != T1_CNT_W'(1)) fault = 1'b1;
                                else state_d = ST_COMMAND;
                            end else if (pkt_cnt != '0) begin
                                remain_d = CNT_W'(pkt_cnt);
                                pwr_d    = (hdr.op == OP_WRITE);
                                state_d  = ST_PAYLOAD;
                            end
                        end
                    end
                end
                ST_PAYLOAD: begin
                    o_wr     = pwr_q;
                    remain_d = remain_q - CNT_ONE;
                    if (remain_q == CNT_ONE) state_d = ST_HEADER;
                end
                ST_FRAMEADR: begin
                    if (frame_ok) begin
                        o_wr    = 1'b1;
                        o_far   = 1'b1;
                        state_d = ST_HEADER;
                    end else begin
                        fault = 1'b1;
                    end
                end
                ST_COMMAND: begin
                    if (cmd_ok) begin
                        o_wr    = 1'b1;
                        o_cmd   = 1'b1;
                        state_d = (norm[4:0] == CMD_DESYNC) ? ST_HUNT : ST_HEADER;
                    end else begin
                        fault = 1'b1;
                    end
                end
                ST_HALT: ;
                default: fault = 1'b1;
            endcase
        end
        if (fault) state_d = ST_HALT;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_HUNT;
            last_q   <= '0;
            remain_q <= '0;
            pwr_q    <= 1'b0;
        end else begin
            state_q  <= state_d;
            last_q   <= last_d;
            remain_q <= remain_d;
            pwr_q    <= pwr_d;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_strobe  <= 1'b0;
            far_strobe <= 1'b0;
            cmd_strobe <= 1'b0;
            err        <= 1'b0;
            wr_addr    <= '0;
            wr_data    <= '0;
            far_blk    <= '0;
            far_top    <= 1'b0;
            far_row    <= '0;
            far_col    <= '0;
            far_minor  <= '0;
            cmd_code   <= '0;
        end else begin
            wr_strobe  <= o_wr;
            far_strobe <= o_far;
            cmd_strobe <= o_cmd;
            err        <= err | fault;
            if (o_wr) begin
                wr_addr <= last_q;
                wr_data <= norm;
            end
            if (o_far) begin
                far_blk   <= frame.blk;
                far_top   <= frame.top;
                far_row   <= frame.row;
                far_col   <= frame.col;
                far_minor <= frame.minor;
            end
            if (o_cmd) cmd_code <= norm[4:0];
        end
    end

    // R8: a frame-address strobe always rides on a write to address 1 with a legal block type
    assert_far_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        far_strobe |-> (wr_strobe && wr_addr == REG_FRAME_ADR &&
                        (far_blk inside {3'd0, 3'd1, 3'd2, 3'd7})));

    // R9: a command strobe always rides on a write to address 4
    assert_cmd_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_strobe |-> (wr_strobe && wr_addr == REG_COMMAND));

    // R11: error is sticky and blocks input
    assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
    assert_err_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !in_ready);

    // R12: a strobe follows an accepted word by exactly one cycle
    assert_strobe_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |-> $past(in_valid && in_ready));

endmodule

// File: tb/cfg_pkt_parser_tb.sv
`timescale 1ns/1ps
module cfg_pkt_parser_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready, wr_strobe, far_strobe, cmd_strobe, err, far_top;
    logic [4:0]  wr_addr, far_row, cmd_code;
    logic [31:0] wr_data;
    logic [2:0]  far_blk;
    logic [9:0]  far_col;
    logic [6:0]  far_minor;

    always #2.5 clk = ~clk;

    cfg_pkt_parser dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .wr_strobe(wr_strobe), .wr_addr(wr_addr),
        .wr_data(wr_data), .far_strobe(far_strobe), .far_blk(far_blk),
        .far_top(far_top), .far_row(far_row), .far_col(far_col),
        .far_minor(far_minor), .cmd_strobe(cmd_strobe), .cmd_code(cmd_code),
        .err(err)
    );

    int total = 0;
    int bad   = 0;

    // reference model state
    int          mst;
    bit          m_swap, m_err, m_pwr;
    logic [4:0]  m_last;
    int unsigned m_rem;
    string       m_ptag;
    bit          e_wr, e_far, e_cmd;
    logic [4:0]  e_addr, e_code;
    logic [31:0] e_data;
    logic [25:0] e_farw;

    function automatic logic [31:0] bsw(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    function automatic logic [31:0] h1(input int op, input int addr, input int cnt);
        return {3'd1, 2'(op), 9'd0, 5'(addr), 3'd0, 10'(cnt)};
    endfunction

    function automatic logic [31:0] h2(input int op, input int cnt);
        return {3'd2, 2'(op), 1'b0, 26'(cnt)};
    endfunction

    function automatic logic [31:0] fw(input int blk, input int top, input int row,
                                       input int col, input int minor);
        return {6'd0, 3'(blk), 1'(top), 5'(row), 10'(col), 7'(minor)};
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic model(input logic [31:0] w, output string tag);
        logic [31:0] n;
        int unsigned cnt;
        e_wr = 0; e_far = 0; e_cmd = 0; tag = "R12";
        if (m_err) begin tag = "R11"; return; end
        n = m_swap ? bsw(w) : w;
        case (mst)
            0: begin
                tag = m_swap ? "R4" : "R2";
                if (n == 32'hBB000000) begin
                    tag = "R4";
                    if (m_swap) m_err = 1; else m_swap = 1;
                end else if (n == 32'hAA995566) mst = 1;
            end
            1: begin
                if (n == 32'hFFFFFFFF) tag = "R3";
                else if (n[28:27] == 2'd3 || (n[31:29] != 3'd1 && n[31:29] != 3'd2)) begin
                    m_err = 1; tag = "R11";
                end else if (n[31:29] == 3'd1) begin
                    m_last = n[17:13]; cnt = n[9:0]; tag = "R5"; m_ptag = "R5";
                    if (n[28:27] == 2'd2 && m_last == 5'd1) begin
                        tag = "R8";
                        if (cnt != 1) m_err = 1; else mst = 3;
                    end else if (n[28:27] == 2'd2 && m_last == 5'd4) begin
                        tag = "R9";
                        if (cnt != 1) m_err = 1; else mst = 4;
                    end else if (cnt == 0) tag = "R6";
                    else begin m_rem = cnt; m_pwr = (n[28:27] == 2'd2); mst = 2; end
                end else begin
                    cnt = n[25:0]; tag = "R7"; m_ptag = "R7";
                    if (cnt == 0) tag = "R6";
                    else begin m_rem = cnt; m_pwr = (n[28:27] == 2'd2); mst = 2; end
                end
            end
            2: begin
                tag = m_ptag;
                if (m_pwr) begin e_wr = 1; e_addr = m_last; e_data = n; end
                m_rem--;
                if (m_rem == 0) mst = 1;
            end
            3: begin
                tag = "R8";
                if (n[25:23] inside {3'd0, 3'd1, 3'd2, 3'd7}) begin
                    e_wr = 1; e_far = 1; e_addr = 5'd1; e_data = n; e_farw = n[25:0]; mst = 1;
                end else m_err = 1;
            end
            4: begin
                tag = "R9";
                if (n <= 13 && n != 6 && n != 12) begin
                    e_wr = 1; e_cmd = 1; e_addr = 5'd4; e_data = n; e_code = n[4:0];
                    if (n == 13) begin mst = 0; tag = "R10"; end else mst = 1;
                end else m_err = 1;
            end
            default: ;
        endcase
    endtask

    task automatic check(input string tag);
        chk(tag, "wr_strobe", 32'(wr_strobe), 32'(e_wr));
        if (e_wr) begin
            chk(tag, "wr_addr", 32'(wr_addr), 32'(e_addr));
            chk(tag, "wr_data", wr_data, e_data);
        end
        chk(tag, "far_strobe", 32'(far_strobe), 32'(e_far));
        if (e_far)
            chk(tag, "far_fields", 32'({far_blk, far_top, far_row, far_col, far_minor}), 32'(e_farw));
        chk(tag, "cmd_strobe", 32'(cmd_strobe), 32'(e_cmd));
        if (e_cmd) chk(tag, "cmd_code", 32'(cmd_code), 32'(e_code));
        chk(tag, "err", 32'(err), 32'(m_err));
        chk(tag, "in_ready", 32'(in_ready), 32'(!m_err));
    endtask

    task automatic send(input logic [31:0] w);
        string tag;
        in_valid = 1'b1;
        in_data  = w;
        model(w, tag);
        @(negedge clk);
        check(tag);
        in_valid = 1'b0;
    endtask

    task automatic idle();
        e_wr = 0; e_far = 0; e_cmd = 0;
        in_valid = 1'b0;
        @(negedge clk);
        check("R12");
    endtask

    task automatic do_reset();
        rst_n = 1'b0; in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mst = 0; m_swap = 0; m_err = 0; m_pwr = 0; m_last = '0; m_rem = 0; m_ptag = "R5";
        e_wr = 0; e_far = 0; e_cmd = 0;
        check("R1");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL R12 watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();

        // R2: hunting ignores everything but alignment
        send(h1(2, 5, 1)); send(32'h0000_1234); send(32'hFFFFFFFF);
        send(32'h000000BB); send(32'h11220044);
        send(32'hAA995566);
        // R3 pad in header state, R5 generic write
        send(32'hFFFFFFFF);
        send(h1(2, 5, 2)); send(32'hDEAD_BEEF); send(32'h0000_0001);
        idle();
        // R5 read payload consumed silently
        send(h1(1, 9, 1)); send(32'hCAFE_F00D);
        // R6 count 0 then header
        send(h1(2, 3, 0)); send(h1(0, 0, 0));
        // R7 type 2 follows last type 1 address
        send(h1(2, 2, 0)); send(h2(2, 3));
        send(32'h1111_1111); send(32'hFFFFFFFF); send(32'h3333_3333);
        // R8 frame address decode
        send(h1(2, 1, 1)); send(fw(7, 1, 31, 1023, 127));
        send(h1(2, 1, 1)); send(fw(1, 0, 5, 300, 9));
        // R9 command, R10 desync then ignored header, re-align
        send(h1(2, 4, 1)); send(32'd5);
        send(h1(2, 4, 1)); send(32'd13);
        send(h1(2, 6, 1)); send(32'h5555_5555);
        send(32'hAA995566); send(h1(2, 6, 1)); send(32'h6666_6666);

        // R4 reversed byte order
        do_reset();
        send(32'hBB000000);
        send(bsw(32'hAA995566));
        send(bsw(h1(2, 7, 1))); send(bsw(32'h1234_5678));
        send(bsw(h1(2, 4, 1))); send(bsw(32'd13));
        send(32'h000000BB);
        // R11 halted: later words have no effect
        send(bsw(32'hAA995566)); send(bsw(h1(2, 7, 1))); idle();

        // R11 unknown type and reserved opcode
        do_reset(); send(32'hAA995566); send(32'h0000_0000); send(h1(2, 5, 0));
        do_reset(); send(32'hAA995566); send(h1(3, 5, 1)); idle();
        // R8 bad count and bad block type
        do_reset(); send(32'hAA995566); send(h1(2, 1, 2)); idle();
        do_reset(); send(32'hAA995566); send(h1(2, 1, 1)); send(fw(4, 0, 1, 2, 3)); idle();
        // R9 bad command code
        do_reset(); send(32'hAA995566); send(h1(2, 4, 1)); send(32'd6); idle();

        // random packet stream
        do_reset();
        send(32'hFFFFFFFF); send(32'hAA995566);
        for (int p = 0; p < 300; p++) begin
            int kind;
            int a;
            int c;
            kind = $urandom % 6;
            case (kind)
                0: send(32'hFFFFFFFF);
                1: begin
                    a = $urandom % 32;
                    if (a == 1 || a == 4) a = a + 1;
                    c = $urandom % 4;
                    send(h1(2, a, c));
                    for (int k = 0; k < c; k++) send($urandom);
                end
                2: begin
                    c = $urandom % 4;
                    send(h2(2, c));
                    for (int k = 0; k < c; k++) send($urandom);
                end
                3: begin
                    c = $urandom % 3;
                    send(h1(1, $urandom % 32 == 1 ? 0 : 3, c));
                    for (int k = 0; k < c; k++) send($urandom);
                end
                4: begin
                    int bl;
                    bl = $urandom % 4;
                    if (bl == 3) bl = 7;
                    send(h1(2, 1, 1));
                    send(fw(bl, $urandom % 2, $urandom % 32, $urandom % 1024, $urandom % 128));
                end
                default: begin
                    c = $urandom % 11;
                    if (c == 6) c = 11;
                    send(h1(2, 4, 1));
                    send(32'(c));
                end
            endcase
            if ($urandom % 4 == 0) idle();
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule